// File: doc/BRIEF.md
# Redundant-Copy Fingerprint Checker

This block lets a critical task run twice on different cores at different times, without lock step, and still catch a wrong result. While a critical task runs, the core sends each architectural register write, store value and load/store address over a shared trace port, one 32-bit word per cycle. A per-core accumulator folds every word into a running 16-bit CRC fingerprint. When the task ends, the fingerprint goes into a buffer slot chosen by the task ID. The slot holds it until the other copies of that task have finished.

When a second copy of the same task ends, its fingerprint is compared with the stored one. If they are equal, the task's external outputs may be committed, and the slot is freed. If they differ, the block asks the scheduler for a third run. The third fingerprint is then compared with both stored values. This names the core whose result disagrees with the other two, or flags the fault as unresolvable when all three differ.

Each buffer slot carries a parity bit. A corrupted slot is reported as a buffer fault instead of being trusted. Tasks started as non-critical are not fingerprinted and leave the buffer untouched. Reset is asynchronous and active low. Its release is synchronised inside the block, so the block accepts input from the third clock edge after `rst_n` rises.

Top module: `redund_sig_checker`

## Requirements
- R1: While reset is asserted, and after it until the first critical task ends, every output is low and every buffer slot is empty.
- R2: A fingerprint starts at 0xFFFF when a task is started. Each trace word is folded in most significant bit first with the polynomial 0x1021, with no bit reflection and no final XOR. A task that ends with no trace words reports 0xFFFF.
- R3: When a critical task ends and the slot indexed by its 2-bit task ID is empty, the fingerprint is stored. `done_o` pulses with that fingerprint on `done_fp_o`, and `release_o`, `retry_o` and `loc_v_o` all stay low.
- R4: When a critical task ends, its slot holds one fingerprint and the two are equal, `release_o` pulses and the slot is freed. The next copy with that task ID is then treated as a first copy.
- R5: When a critical task ends, its slot holds one fingerprint and the two differ, `retry_o` pulses. Both fingerprints and both core IDs are kept.
- R6: When a third copy ends, `loc_v_o` pulses and the slot is freed. If the third fingerprint equals the first, `loc_core_o` names the second copy's core. If it equals the second, `loc_core_o` names the first copy's core. In either of these cases `release_o` also pulses. If it equals neither, `unres_o` pulses instead, with no release.
- R7: A task started with `start_crit_i` low produces no `done_o` when it ends and changes no slot. Trace words addressed to a core with no critical task running are ignored.
- R8: Each slot keeps a parity bit over its stored contents. If a task ends on a non-empty slot whose parity no longer matches, `buf_fault_o` pulses, `release_o`, `retry_o` and `loc_v_o` stay low, and the slot is freed. `seu_v_i` flips bit 0 of the first stored fingerprint of slot `seu_slot_i` without updating parity, which models a soft upset.
- R9: Each core has its own accumulator. Trace words for different cores may interleave on the shared port, and each core's fingerprint folds only its own words.
- R10: Starting a task on a core that is already running reseeds that core's fingerprint to 0xFFFF, and earlier trace words are discarded.
- R11: All results (`done_o`, `release_o`, `retry_o`, `loc_v_o`, `unres_o`, `buf_fault_o`) are single-cycle pulses registered at the clock edge that samples `end_v_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_v_i | input | 1 | Task starts on core `start_core_i` |
| start_core_i | input | 2 | Core that starts a task |
| start_crit_i | input | 1 | 1 = the started task is critical |
| trc_v_i | input | 1 | Trace word valid |
| trc_core_i | input | 2 | Core the trace word belongs to |
| trc_word_i | input | 32 | Register write value, store value or access address |
| end_v_i | input | 1 | Task ends on core `end_core_i` |
| end_core_i | input | 2 | Core whose task ends |
| end_task_i | input | 2 | Task ID, which selects the buffer slot |
| seu_v_i | input | 1 | Upset injection pulse |
| seu_slot_i | input | 2 | Slot hit by the upset |
| done_o | output | 1 | A critical copy completed |
| done_task_o | output | 2 | Task ID of the completed copy |
| done_fp_o | output | 16 | Fingerprint of the completed copy |
| release_o | output | 1 | Agreement reached; outputs may be committed |
| retry_o | output | 1 | Mismatch; a third run is needed |
| loc_v_o | output | 1 | Third-copy arbitration done |
| loc_core_o | output | 2 | Core judged faulty |
| unres_o | output | 1 | All three fingerprints differ |
| buf_fault_o | output | 1 | Parity error in the buffer slot |

## Verification
The bench walks a schedule in which task IDs interleave, and in which one non-critical run lands between two critical copies of the same task. A design that touched the slot for a non-critical run would then report retry instead of storing or matching. Third-copy arbitration is driven toward both agreeing fingerprints and toward none, which catches swapped core IDs and any release granted on an unresolvable fault. Directed cases cover an upset slot, interleaved traces for two cores, a restart before the end of a task, and a task with no trace words. These catch, in order: a parity check that never fires, words folded into the wrong core's accumulator, a missing reseed, and a wrong seed.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_ONE   = 2'd1,
    SL_TWO   = 2'd2
  } slot_st_e;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_A    = 2'd1,
    WR_B    = 2'd2,
    WR_FREE = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/rsc_crc_acc.sv
module rsc_crc_acc #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned WORD_W = 32,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              crit_i,
  input  logic              word_v_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              end_i,
  output logic              active_o,
  output logic [CRC_W-1:0]  crc_o
);
  logic             active_q, active_d;
  logic [CRC_W-1:0] crc_q, crc_d, fold;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_q;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word_i[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    fold = c;
  end

  always_comb begin
    active_d = active_q;
    crc_d    = crc_q;
    if (start_i) begin
      active_d = crit_i;
      crc_d    = SEED;
    end else if (end_i) begin
      active_d = 1'b0;
    end else if (word_v_i && active_q) begin
      crc_d = fold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      crc_q    <= SEED;
    end else begin
      active_q <= active_d;
      crc_q    <= crc_d;
    end
  end

  assign active_o = active_q;
  assign crc_o    = crc_q;

  // R7: an idle accumulator ignores trace words
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_i) |=> $stable(crc_q));
endmodule

// File: rtl/rsc_slot_buf.sv
module rsc_slot_buf
  import rsc_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned CORE_W = 2,
  localparam int unsigned IDX_W = $clog2(NSLOT),
  localparam int unsigned ENT_W = CRC_W + CORE_W,
  localparam int unsigned DAT_W = 2 * ENT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  wr_kind_e          wr_kind_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CRC_W-1:0]  wr_fp_i,
  input  logic [CORE_W-1:0] wr_core_i,
  input  logic              seu_i,
  input  logic [IDX_W-1:0]  seu_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output slot_st_e          rd_st_o,
  output logic [CRC_W-1:0]  rd_fpa_o,
  output logic [CORE_W-1:0] rd_corea_o,
  output logic [CRC_W-1:0]  rd_fpb_o,
  output logic [CORE_W-1:0] rd_coreb_o,
  output logic              rd_par_ok_o
);
  logic [DAT_W-1:0] dat_a [NSLOT];
  slot_st_e         st_a  [NSLOT];
  logic             par_a [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [DAT_W-1:0] dat_q, dat_d;
    slot_st_e         st_q, st_d;
    logic             par_q, par_d;
    logic             hit;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_comb begin
      dat_d = dat_q;
      st_d  = st_q;
      par_d = par_q;
      if (hit) begin
        unique case (wr_kind_i)
          WR_A: begin
            dat_d = {wr_fp_i, wr_core_i, {ENT_W{1'b0}}};
            st_d  = SL_ONE;
            par_d = ^{wr_fp_i, wr_core_i};
          end
          WR_B: begin
            dat_d = {dat_q[DAT_W-1 -: ENT_W], wr_fp_i, wr_core_i};
            st_d  = SL_TWO;
            par_d = ^{dat_q[DAT_W-1 -: ENT_W], wr_fp_i, wr_core_i};
          end
          WR_FREE: st_d = SL_EMPTY;
          default: ;
        endcase
      end
      if (seu_i && (seu_idx_i == IDX_W'(g))) begin
        dat_d[DAT_W-CRC_W] = ~dat_d[DAT_W-CRC_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
        st_q  <= SL_EMPTY;
        par_q <= 1'b0;
      end else begin
        dat_q <= dat_d;
        st_q  <= st_d;
        par_q <= par_d;
      end
    end

    assign dat_a[g] = dat_q;
    assign st_a[g]  = st_q;
    assign par_a[g] = par_q;
  end

  logic [DAT_W-1:0] rd_dat;
  assign rd_dat      = dat_a[rd_idx_i];
  assign rd_st_o     = st_a[rd_idx_i];
  assign rd_fpa_o    = rd_dat[DAT_W-1 -: CRC_W];
  assign rd_corea_o  = rd_dat[ENT_W +: CORE_W];
  assign rd_fpb_o    = rd_dat[CORE_W +: CRC_W];
  assign rd_coreb_o  = rd_dat[CORE_W-1:0];
  assign rd_par_ok_o = ((^rd_dat) == par_a[rd_idx_i]);

  // R3: a first fingerprint only goes into an empty slot
  a_r3_a_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_kind_i == WR_A) |-> (st_a[wr_idx_i] == SL_EMPTY));
  // R5: a second fingerprint only follows a first one
  a_r5_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_kind_i == WR_B) |-> (st_a[wr_idx_i] == SL_ONE));
endmodule

// File: rtl/rsc_judge.sv
module rsc_judge
  import rsc_pkg::*;
#(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned CORE_W = 2
) (
  input  logic              end_i,
  input  slot_st_e          st_i,
  input  logic [CRC_W-1:0]  fpa_i,
  input  logic [CORE_W-1:0] corea_i,
  input  logic [CRC_W-1:0]  fpb_i,
  input  logic [CORE_W-1:0] coreb_i,
  input  logic              par_ok_i,
  input  logic [CRC_W-1:0]  fp_i,
  output logic              wr_en_o,
  output wr_kind_e          wr_kind_o,
  output logic              rel_o,
  output logic              retry_o,
  output logic              loc_o,
  output logic [CORE_W-1:0] loc_core_o,
  output logic              unres_o,
  output logic              bfault_o
);
  always_comb begin
    wr_en_o    = 1'b0;
    wr_kind_o  = WR_NONE;
    rel_o      = 1'b0;
    retry_o    = 1'b0;
    loc_o      = 1'b0;
    loc_core_o = '0;
    unres_o    = 1'b0;
    bfault_o   = 1'b0;
    if (end_i) begin
      wr_en_o = 1'b1;
      if (st_i == SL_EMPTY) begin
        wr_kind_o = WR_A;
      end else if (!par_ok_i) begin
        bfault_o  = 1'b1;
        wr_kind_o = WR_FREE;
      end else if (st_i == SL_ONE) begin
        if (fp_i == fpa_i) begin
          rel_o     = 1'b1;
          wr_kind_o = WR_FREE;
        end else begin
          retry_o   = 1'b1;
          wr_kind_o = WR_B;
        end
      end else begin
        loc_o     = 1'b1;
        wr_kind_o = WR_FREE;
        if (fp_i == fpa_i) begin
          rel_o      = 1'b1;
          loc_core_o = coreb_i;
        end else if (fp_i == fpb_i) begin
          rel_o      = 1'b1;
          loc_core_o = corea_i;
        end else begin
          unres_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/redund_sig_checker.sv
module redund_sig_checker
  import rsc_pkg::*;
#(
  parameter int unsigned NCORE  = 3,
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned WORD_W = 32,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_v_i,
  input  logic [$clog2(NCORE)-1:0]   start_core_i,
  input  logic                       start_crit_i,
  input  logic                       trc_v_i,
  input  logic [$clog2(NCORE)-1:0]   trc_core_i,
  input  logic [WORD_W-1:0]          trc_word_i,
  input  logic                       end_v_i,
  input  logic [$clog2(NCORE)-1:0]   end_core_i,
  input  logic [$clog2(NSLOT)-1:0]   end_task_i,
  input  logic                       seu_v_i,
  input  logic [$clog2(NSLOT)-1:0]   seu_slot_i,
  output logic                       done_o,
  output logic [$clog2(NSLOT)-1:0]   done_task_o,
  output logic [CRC_W-1:0]           done_fp_o,
  output logic                       release_o,
  output logic                       retry_o,
  output logic                       loc_v_o,
  output logic [$clog2(NCORE)-1:0]   loc_core_o,
  output logic                       unres_o,
  output logic                       buf_fault_o
);
  localparam int unsigned CORE_W = $clog2(NCORE);
  localparam int unsigned IDX_W  = $clog2(NSLOT);

  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [CRC_W-1:0] crc_a [NCORE];
  logic             act_a [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    rsc_crc_acc #(
      .CRC_W(CRC_W), .WORD_W(WORD_W), .POLY(POLY), .SEED(SEED)
    ) u_acc (
      .clk     (clk),
      .rst_n   (srst_n),
      .start_i (start_v_i && (start_core_i == CORE_W'(c))),
      .crit_i  (start_crit_i),
      .word_v_i(trc_v_i && (trc_core_i == CORE_W'(c))),
      .word_i  (trc_word_i),
      .end_i   (end_v_i && (end_core_i == CORE_W'(c))),
      .active_o(act_a[c]),
      .crc_o   (crc_a[c])
    );
  end

  logic [CRC_W-1:0] cur_fp;
  logic             cur_act;
  always_comb begin
    cur_fp  = '0;
    cur_act = 1'b0;
    for (int c = 0; c < NCORE; c++) begin
      if (end_core_i == CORE_W'(c)) begin
        cur_fp  = crc_a[c];
        cur_act = act_a[c];
      end
    end
  end

  logic crit_end;
  assign crit_end = end_v_i && cur_act;

  slot_st_e          rd_st;
  logic [CRC_W-1:0]  rd_fpa, rd_fpb;
  logic [CORE_W-1:0] rd_corea, rd_coreb;
  logic              rd_par_ok;
  logic              wr_en;
  wr_kind_e          wr_kind;
  logic              j_rel, j_retry, j_loc, j_unres, j_bfault;
  logic [CORE_W-1:0] j_loc_core;

  rsc_slot_buf #(.NSLOT(NSLOT), .CRC_W(CRC_W), .CORE_W(CORE_W)) u_buf (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en_i    (wr_en),
    .wr_kind_i  (wr_kind),
    .wr_idx_i   (end_task_i),
    .wr_fp_i    (cur_fp),
    .wr_core_i  (end_core_i),
    .seu_i      (seu_v_i),
    .seu_idx_i  (seu_slot_i),
    .rd_idx_i   (end_task_i),
    .rd_st_o    (rd_st),
    .rd_fpa_o   (rd_fpa),
    .rd_corea_o (rd_corea),
    .rd_fpb_o   (rd_fpb),
    .rd_coreb_o (rd_coreb),
    .rd_par_ok_o(rd_par_ok)
  );

  rsc_judge #(.CRC_W(CRC_W), .CORE_W(CORE_W)) u_judge (
    .end_i     (crit_end),
    .st_i      (rd_st),
    .fpa_i     (rd_fpa),
    .corea_i   (rd_corea),
    .fpb_i     (rd_fpb),
    .coreb_i   (rd_coreb),
    .par_ok_i  (rd_par_ok),
    .fp_i      (cur_fp),
    .wr_en_o   (wr_en),
    .wr_kind_o (wr_kind),
    .rel_o     (j_rel),
    .retry_o   (j_retry),
    .loc_o     (j_loc),
    .loc_core_o(j_loc_core),
    .unres_o   (j_unres),
    .bfault_o  (j_bfault)
  );

  logic              done_d;
  logic [IDX_W-1:0]  task_d;
  logic [CRC_W-1:0]  fp_d;
  always_comb begin
    done_d = crit_end;
    task_d = crit_end ? end_task_i : '0;
    fp_d   = crit_end ? cur_fp : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_o      <= 1'b0;
      done_task_o <= '0;
      done_fp_o   <= '0;
      release_o   <= 1'b0;
      retry_o     <= 1'b0;
      loc_v_o     <= 1'b0;
      loc_core_o  <= '0;
      unres_o     <= 1'b0;
      buf_fault_o <= 1'b0;
    end else begin
      done_o      <= done_d;
      done_task_o <= task_d;
      done_fp_o   <= fp_d;
      release_o   <= j_rel;
      retry_o     <= j_retry;
      loc_v_o     <= j_loc;
      loc_core_o  <= j_loc_core;
      unres_o     <= j_unres;
      buf_fault_o <= j_bfault;
    end
  end

  // R7: a non-critical end never yields a completion
  a_r7_noncrit_silent: assert property (@(posedge clk) disable iff (!srst_n)
    (end_v_i && !cur_act) |=> !done_o);
  // R4 / R5: release and retry are exclusive
  a_r4_rel_not_retry: assert property (@(posedge clk) disable iff (!srst_n)
    !(release_o && retry_o));
  // R6: an unresolvable verdict is part of an arbitration
  a_r6_unres_in_loc: assert property (@(posedge clk) disable iff (!srst_n)
    unres_o |-> (loc_v_o && !release_o));
  // R8: a buffer fault suppresses every verdict
  a_r8_fault_alone: assert property (@(posedge clk) disable iff (!srst_n)
    buf_fault_o |-> !(release_o || retry_o || loc_v_o));
  // R11: every verdict rides on a completion pulse
  a_r11_verdict_done: assert property (@(posedge clk) disable iff (!srst_n)
    (release_o || retry_o || loc_v_o || buf_fault_o) |-> done_o);
endmodule

// File: tb/redund_sig_checker_bench.sv
module redund_sig_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_v = 0, start_crit = 0, trc_v = 0, end_v = 0, seu_v = 0;
  logic [1:0]  start_core = 0, trc_core = 0, end_core = 0, end_task = 0, seu_slot = 0;
  logic [31:0] trc_word = 0;
  logic        done, release_s, retry_s, loc_v, unres, bfault;
  logic [1:0]  done_task, loc_core;
  logic [15:0] done_fp;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  redund_sig_checker u_redund_sig_checker (
    .clk(clk), .rst_n(rst_n),
    .start_v_i(start_v), .start_core_i(start_core), .start_crit_i(start_crit),
    .trc_v_i(trc_v), .trc_core_i(trc_core), .trc_word_i(trc_word),
    .end_v_i(end_v), .end_core_i(end_core), .end_task_i(end_task),
    .seu_v_i(seu_v), .seu_slot_i(seu_slot),
    .done_o(done), .done_task_o(done_task), .done_fp_o(done_fp),
    .release_o(release_s), .retry_o(retry_s), .loc_v_o(loc_v),
    .loc_core_o(loc_core), .unres_o(unres), .buf_fault_o(bfault)
  );

  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] core, input logic crit);
    @(negedge clk); start_v = 1; start_core = core; start_crit = crit;
    @(negedge clk); start_v = 0;
  endtask

  task automatic do_word(input logic [1:0] core, input logic [31:0] w);
    @(negedge clk); trc_v = 1; trc_core = core; trc_word = w;
    @(negedge clk); trc_v = 0;
  endtask

  // drives the end; outputs are sampled one negedge later, after the sampling edge
  task automatic do_end(input logic [1:0] core, input logic [1:0] tid);
    @(negedge clk); end_v = 1; end_core = core; end_task = tid;
    @(negedge clk); end_v = 0;
  endtask

  // {core, tid, crit, code, loc core, pad, seed}
  // codes: 0 none, 1 stored, 2 release, 3 retry, 4 located+release, 5 unresolvable
  localparam logic [31:0] SA = 32'hCAFE_0001, SB = 32'h1234_5678,
                          SC = 32'h0BAD_F00D, SD = 32'h7777_0000;
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b1, 3'd1, 2'd0, 6'd0, SA},
    {2'd1, 2'd0, 1'b1, 3'd2, 2'd0, 6'd0, SA},
    {2'd0, 2'd1, 1'b1, 3'd1, 2'd0, 6'd0, SA},
    {2'd1, 2'd1, 1'b1, 3'd3, 2'd0, 6'd0, SB},
    {2'd2, 2'd1, 1'b1, 3'd4, 2'd1, 6'd0, SA},
    {2'd0, 2'd2, 1'b1, 3'd1, 2'd0, 6'd0, SC},
    {2'd1, 2'd2, 1'b1, 3'd3, 2'd0, 6'd0, SD},
    {2'd2, 2'd2, 1'b1, 3'd4, 2'd0, 6'd0, SD},
    {2'd0, 2'd3, 1'b1, 3'd1, 2'd0, 6'd0, SA},
    {2'd1, 2'd3, 1'b0, 3'd0, 2'd0, 6'd0, SB},
    {2'd2, 2'd3, 1'b1, 3'd3, 2'd0, 6'd0, SB},
    {2'd1, 2'd3, 1'b1, 3'd5, 2'd0, 6'd0, SC},
    {2'd2, 2'd0, 1'b1, 3'd1, 2'd0, 6'd0, SC},
    {2'd0, 2'd0, 1'b1, 3'd2, 2'd0, 6'd0, SC}
  };

  function automatic logic [15:0] fp_of(input logic [31:0] s);
    logic [15:0] r = 16'hFFFF;
    r = ref_fold(r, s);
    r = ref_fold(r, ~s);
    r = ref_fold(r, s ^ 32'h1357_9BDF);
    return r;
  endfunction

  task automatic run_copy(input logic [1:0] core, input logic [1:0] tid,
                          input logic crit, input logic [31:0] s);
    do_start(core, crit);
    do_word(core, s);
    do_word(core, ~s);
    do_word(core, s ^ 32'h1357_9BDF);
    do_end(core, tid);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(!(done | release_s | retry_s | loc_v | unres | bfault), "R1 in reset",
        {26'd0, done, release_s, retry_s, loc_v, unres, bfault}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!(done | release_s | retry_s | loc_v | unres | bfault), "R1 after reset",
        {26'd0, done, release_s, retry_s, loc_v, unres, bfault}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] vc, vt, vl;
      logic       vcr;
      logic [2:0] code;
      logic [31:0] vs;
      {vc, vt, vcr, code, vl} = VEC[v][47:38];
      vs = VEC[v][31:0];
      run_copy(vc, vt, vcr, vs);
      chk(done == (code != 0), (code == 0) ? "R7 noncritical done" : "R11 done pulse",
          {31'd0, done}, {31'd0, code != 0});
      if (code != 0) begin
        chk(done_fp == fp_of(vs), "R2 fingerprint", {16'd0, done_fp}, {16'd0, fp_of(vs)});
        chk(done_task == vt, "R3 task id", {30'd0, done_task}, {30'd0, vt});
      end
      chk(release_s == (code == 2 || code == 4), (code == 2) ? "R4 release" : "R6 release",
          {31'd0, release_s}, {31'd0, (code == 2 || code == 4)});
      chk(retry_s == (code == 3), (code == 3) ? "R5 retry" : "R3 no retry",
          {31'd0, retry_s}, {31'd0, code == 3});
      chk(loc_v == (code >= 4) && unres == (code == 5), "R6 arbitration",
          {30'd0, loc_v, unres}, {30'd0, code >= 4, code == 5});
      if (code == 4)
        chk(loc_core == vl, "R6 faulty core", {30'd0, loc_core}, {30'd0, vl});
      @(negedge clk);
      chk(!(done | release_s | retry_s | loc_v), "R11 single pulse",
          {28'd0, done, release_s, retry_s, loc_v}, 0);
    end

    // R8: upset in a stored slot
    run_copy(2'd0, 2'd0, 1'b1, SA);
    @(negedge clk); seu_v = 1; seu_slot = 2'd0;
    @(negedge clk); seu_v = 0;
    run_copy(2'd1, 2'd0, 1'b1, SA);
    chk(bfault && !release_s && !retry_s && !loc_v, "R8 parity fault",
        {28'd0, bfault, release_s, retry_s, loc_v}, 32'h8);
    run_copy(2'd2, 2'd0, 1'b1, SC);
    chk(done && !bfault && !release_s && !retry_s, "R8 slot freed",
        {29'd0, bfault, release_s, retry_s}, 0);
    run_copy(2'd0, 2'd0, 1'b1, SC);
    chk(release_s, "R4 release after refill", {31'd0, release_s}, 1);

    // R2: no trace words gives the seed
    do_start(2'd0, 1'b1);
    do_end(2'd0, 2'd0);
    chk(done && done_fp == 16'hFFFF, "R2 empty task", {16'd0, done_fp}, 32'hFFFF);
    do_start(2'd1, 1'b1);
    do_end(2'd1, 2'd0);
    chk(release_s, "R4 empty pair", {31'd0, release_s}, 1);

    // R9: interleaved traces for two cores
    begin
      logic [15:0] e0, e1;
      e0 = ref_fold(ref_fold(16'hFFFF, 32'hA5A5_0000), 32'h0000_FFFF);
      e1 = ref_fold(16'hFFFF, 32'h0F0F_1234);
      do_start(2'd0, 1'b1);
      do_start(2'd1, 1'b1);
      do_word(2'd0, 32'hA5A5_0000);
      do_word(2'd1, 32'h0F0F_1234);
      do_word(2'd2, 32'hDEAD_BEEF);
      do_word(2'd0, 32'h0000_FFFF);
      do_end(2'd0, 2'd1);
      chk(done_fp == e0, "R9 core0 fingerprint", {16'd0, done_fp}, {16'd0, e0});
      do_end(2'd1, 2'd2);
      chk(done_fp == e1, "R9 core1 fingerprint", {16'd0, done_fp}, {16'd0, e1});
    end

    // R10: restart reseeds
    begin
      logic [15:0] e2;
      e2 = ref_fold(16'hFFFF, 32'h0000_0001);
      do_start(2'd2, 1'b1);
      do_word(2'd2, 32'h8000_0000);
      do_start(2'd2, 1'b1);
      do_word(2'd2, 32'h0000_0001);
      do_end(2'd2, 2'd3);
      chk(done && done_fp == e2, "R10 restart", {16'd0, done_fp}, {16'd0, e2});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule